// File: doc/BRIEF.md
# Matrix-Based Erasure Parity Encoder

This block turns a set of equal-length source data blocks into a larger set of coded blocks. Every coded byte is a GF(2^8) linear combination of the bytes in the same column of all source blocks. The weights come from a coefficient matrix that is loaded through a small write port before encoding starts. The number of coded rows is larger than the number of sources, typically the source count plus three. That lets a storage system rebuild lost blocks later.

Source data streams in one column group at a time. A beat carries LANES bytes of one source block, and the beats for sources 0 to srcs-1 arrive in order. Each lane is an independent byte column. All lanes share the coefficient chosen for the current source, so one coefficient per destination row is broadcast to every lane. When the last source beat of a group has been taken, the encoder sends out dests beats, one per destination row, and holds off new input until the last row has been accepted.

Top module: `ec_parity_enc`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: When cfg_we is high at a clock edge, cfg_coef is stored as the coefficient for destination row cfg_row and source column cfg_col. Any later column group uses the new value.
- R3: Output lane k (bits 8k+7..8k) of destination row l is the XOR, over sources j = 0..cfg_srcs-1, of V[l][j] times source j lane k. The product is GF(2^8) multiplication reduced by x^8+x^4+x^3+x^2+1 (0x11D).
- R4: Source beats are taken in source order 0..cfg_srcs-1 while in_ready is high. The cycle after the beat for source cfg_srcs-1 is accepted, in_ready is 0 and out_valid is 1. in_ready and out_valid are never high together.
- R5: A group produces exactly cfg_dests output beats in row order 0..cfg_dests-1. out_last is 1 only on row cfg_dests-1. The cycle after that row is accepted, in_ready is 1 again.
- R6: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values.
- R7: A coefficient of 0 adds nothing to a row. A coefficient of 1 passes the source byte through unchanged.
- R8: The accumulators restart at each source-0 beat, so no data from an earlier column group leaks into a later one.
- R9: cfg_srcs and cfg_dests set the active sizes at run time, up to 32 sources and 36 rows. 30 sources with 33 rows is supported, and cfg_dests must exceed cfg_srcs.
- R10: in_valid beats offered while in_ready is 0 are not accepted and do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_srcs | input | 6 | Active source count |
| cfg_dests | input | 6 | Active destination row count |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_row | input | 6 | Coefficient destination row |
| cfg_col | input | 5 | Coefficient source column |
| cfg_coef | input | 8 | Coefficient value |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Source beat ready |
| in_data | input | LANES*8 | Source bytes, lane k in bits 8k+7..8k |
| out_valid | output | 1 | Coded beat valid |
| out_ready | input | 1 | Coded beat ready |
| out_data | output | LANES*8 | Coded bytes of the current row |
| out_last | output | 1 | Marks the final row of a group |

## Verification
A coefficient write takes effect at the edge where it is sampled. Row 0 of a group appears at the ports one cycle after the edge that accepts the last source beat, and each later row appears one cycle after the row before it is accepted. in_ready comes back one cycle after the final row is taken. Reset release passes through a two-flop synchronizer, so the bench waits several cycles before the first check. The bench drives inputs on falling edges and samples at the falling edge right after each accepting rising edge, which is the exact cycle each result is due.

// File: rtl/ec_pkg.sv
package ec_pkg;

  typedef enum logic {ST_IN, ST_OUT} ec_state_e;

  // GF(2^8) product, reduction polynomial 0x11D
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return p;
  endfunction

endpackage

// File: rtl/ec_coef_store.sv
module ec_coef_store #(
  parameter int SRCS_MAX  = 32,
  parameter int DESTS_MAX = 36,
  localparam int SIDX_W = $clog2(SRCS_MAX),
  localparam int DIDX_W = $clog2(DESTS_MAX)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [DIDX_W-1:0]      wr_row,
  input  logic [SIDX_W-1:0]      wr_col,
  input  logic [7:0]             wr_data,
  input  logic [SIDX_W-1:0]      rd_col,
  output logic [DESTS_MAX*8-1:0] rd_coefs
);

  logic [7:0] mem_q [DESTS_MAX][SRCS_MAX];
  logic       wr_ok;

  assign wr_ok = wr_en && (32'(wr_row) < DESTS_MAX) && (32'(wr_col) < SRCS_MAX);

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_row][wr_col] <= wr_data;
  end

  for (genvar d = 0; d < DESTS_MAX; d++) begin : g_rd
    assign rd_coefs[d*8 +: 8] = mem_q[d][rd_col];
  end

endmodule

// File: rtl/ec_mac_array.sv
module ec_mac_array #(
  parameter int DESTS_MAX = 36,
  parameter int LANES     = 16,
  localparam int W      = LANES * 8,
  localparam int DIDX_W = $clog2(DESTS_MAX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   beat_en,
  input  logic                   first,
  input  logic [W-1:0]           in_data,
  input  logic [DESTS_MAX*8-1:0] coefs,
  input  logic [DIDX_W-1:0]      row_sel,
  output logic [W-1:0]           row_data
);

  logic [DESTS_MAX*W-1:0] rows_flat;

  for (genvar d = 0; d < DESTS_MAX; d++) begin : g_row
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_d;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] prod;
      assign prod = ec_pkg::gf_mul(coefs[d*8 +: 8], in_data[k*8 +: 8]);
      assign acc_d[k*8 +: 8] = first ? prod : (acc_q[k*8 +: 8] ^ prod);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (beat_en) acc_q <= acc_d;
    end

    assign rows_flat[d*W +: W] = acc_q;
  end

  always_comb begin
    row_data = '0;
    for (int d = 0; d < DESTS_MAX; d++) begin
      if (row_sel == DIDX_W'(d)) row_data = rows_flat[d*W +: W];
    end
  end

endmodule

// File: rtl/ec_seq.sv
module ec_seq #(
  parameter int SRCS_MAX  = 32,
  parameter int DESTS_MAX = 36,
  localparam int SIDX_W = $clog2(SRCS_MAX),
  localparam int DIDX_W = $clog2(DESTS_MAX),
  localparam int SCNT_W = $clog2(SRCS_MAX + 1),
  localparam int DCNT_W = $clog2(DESTS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SCNT_W-1:0] cfg_srcs,
  input  logic [DCNT_W-1:0] cfg_dests,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              beat_en,
  output logic              first,
  output logic [SIDX_W-1:0] src_idx,
  output logic [DIDX_W-1:0] row_idx
);

  import ec_pkg::*;

  ec_state_e   state_q, state_d;
  logic [SIDX_W-1:0] src_q, src_d;
  logic [DIDX_W-1:0] row_q, row_d;
  logic        last_src, last_row, out_fire;

  assign in_ready  = (state_q == ST_IN);
  assign out_valid = (state_q == ST_OUT);
  assign beat_en   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign last_src  = (src_q == SIDX_W'(cfg_srcs - 1'b1));
  assign last_row  = (row_q == DIDX_W'(cfg_dests - 1'b1));
  assign out_last  = out_valid && last_row;
  assign first     = (src_q == '0);
  assign src_idx   = src_q;
  assign row_idx   = row_q;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    row_d   = row_q;
    if (beat_en) begin
      if (last_src) begin
        state_d = ST_OUT;
        src_d   = '0;
        row_d   = '0;
      end else begin
        src_d = src_q + 1'b1;
      end
    end
    if (out_fire) begin
      if (last_row) begin
        state_d = ST_IN;
        row_d   = '0;
      end else begin
        row_d = row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IN;
      src_q   <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      row_q   <= row_d;
    end
  end

endmodule

// File: rtl/ec_parity_enc.sv
module ec_parity_enc #(
  parameter int SRCS_MAX  = 32,
  parameter int DESTS_MAX = 36,
  parameter int LANES     = 16,
  localparam int W      = LANES * 8,
  localparam int SIDX_W = $clog2(SRCS_MAX),
  localparam int DIDX_W = $clog2(DESTS_MAX),
  localparam int SCNT_W = $clog2(SRCS_MAX + 1),
  localparam int DCNT_W = $clog2(DESTS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SCNT_W-1:0] cfg_srcs,
  input  logic [DCNT_W-1:0] cfg_dests,
  input  logic              cfg_we,
  input  logic [DIDX_W-1:0] cfg_row,
  input  logic [SIDX_W-1:0] cfg_col,
  input  logic [7:0]        cfg_coef,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_data,
  output logic              out_last
);

  logic [1:0]             rst_sync_q;
  logic                   rst_i_n;
  logic                   beat_en, first;
  logic [SIDX_W-1:0]      src_idx;
  logic [DIDX_W-1:0]      row_idx;
  logic [DESTS_MAX*8-1:0] coefs;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ec_seq #(.SRCS_MAX(SRCS_MAX), .DESTS_MAX(DESTS_MAX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_srcs  (cfg_srcs),
    .cfg_dests (cfg_dests),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .beat_en   (beat_en),
    .first     (first),
    .src_idx   (src_idx),
    .row_idx   (row_idx)
  );

  ec_coef_store #(.SRCS_MAX(SRCS_MAX), .DESTS_MAX(DESTS_MAX)) u_coef (
    .clk      (clk),
    .wr_en    (cfg_we),
    .wr_row   (cfg_row),
    .wr_col   (cfg_col),
    .wr_data  (cfg_coef),
    .rd_col   (src_idx),
    .rd_coefs (coefs)
  );

  ec_mac_array #(.DESTS_MAX(DESTS_MAX), .LANES(LANES)) u_mac (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .beat_en  (beat_en),
    .first    (first),
    .in_data  (in_data),
    .coefs    (coefs),
    .row_sel  (row_idx),
    .row_data (out_data)
  );

endmodule

// File: rtl/ec_parity_enc_chk.sv
module ec_parity_enc_chk #(
  parameter int LANES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES*8-1:0] out_data,
  input logic               out_last
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6

  AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R5

  AST_ROW_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid); // R5

  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R5

  AST_BLOCKED_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !in_ready || $past(out_valid && out_ready && out_last)); // R10

endmodule

bind ec_parity_enc ec_parity_enc_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/ec_parity_enc_bench.sv
module ec_parity_enc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int W     = LANES * 8;

  logic         clk, rst_n;
  logic [5:0]   cfg_srcs, cfg_dests, cfg_row;
  logic [4:0]   cfg_col;
  logic [7:0]   cfg_coef;
  logic         cfg_we, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [W-1:0] in_data, out_data;

  int total = 0;
  int fails = 0;

  logic [7:0] vm [36][32];
  logic [7:0] sd [32][LANES];

  ec_parity_enc #(.LANES(LANES)) u_ec_parity_enc (
    .clk(clk), .rst_n(rst_n), .cfg_srcs(cfg_srcs), .cfg_dests(cfg_dests),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_coef(cfg_coef),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  // carry-less product followed by polynomial reduction
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11D << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [W-1:0] expect_row(input int l, input int ns);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [7:0] b;
      b = 8'h00;
      for (int j = 0; j < ns; j++) b = b ^ ref_mul(vm[l][j], sd[j][k]);
      r[k*8 +: 8] = b;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_coef(input int l, input int j, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 6'(l); cfg_col = 5'(j); cfg_coef = v;
    vm[l][j] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_random(input int ns, input int nd);
    for (int l = 0; l < nd; l++)
      for (int j = 0; j < ns; j++) write_coef(l, j, 8'($urandom));
  endtask

  task automatic send_group(input int ns);
    for (int j = 0; j < ns; j++)
      for (int k = 0; k < LANES; k++) sd[j][k] = 8'($urandom);
    for (int j = 0; j < ns; j++) begin
      logic [W-1:0] d;
      for (int k = 0; k < LANES; k++) d[k*8 +: 8] = sd[j][k];
      @(negedge clk);
      in_valid = 1'b1; in_data = d;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  // collect rows; stall_row >= 0 holds out_ready low there while junk is offered
  task automatic collect(input string tag, input int ns, input int nd, input int stall_row);
    @(negedge clk);
    chk("R4 ready after last beat", {127'b0, in_ready}, '0);
    chk("R4 valid after last beat", {127'b0, out_valid}, 1);
    for (int r = 0; r < nd; r++) begin
      if (r == stall_row) begin
        logic [W-1:0] held;
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = {LANES{8'hA5}};
        held      = out_data;
        repeat (3) begin
          @(negedge clk);
          chk("R6 held data", out_data, held);
          chk("R10 in_ready low", {127'b0, in_ready}, '0);
        end
        in_valid = 1'b0;
      end
      out_ready = 1'b1;
      chk({tag, " valid"}, {127'b0, out_valid}, 1);
      chk(tag, out_data, expect_row(r, ns));
      chk("R5 last flag", {127'b0, out_last}, (r == nd - 1) ? 1 : 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R5 ready restored", {127'b0, in_ready}, 1);
    chk("R5 valid cleared", {127'b0, out_valid}, '0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 in_ready", {127'b0, in_ready}, 1);
    chk("R1 out_valid", {127'b0, out_valid}, '0);
  endtask

  task automatic t_unit_coefs;
    cfg_srcs = 6'd4; cfg_dests = 6'd7;
    for (int l = 0; l < 7; l++)
      for (int j = 0; j < 4; j++)
        write_coef(l, j, (l < 4) ? ((l == j) ? 8'h01 : 8'h00) : (l == 5) ? 8'h01 : 8'h00);
    send_group(4);
    collect("R7 zero and unit coefficients", 4, 7, -1);
  endtask

  task automatic t_wide_config;
    cfg_srcs = 6'd30; cfg_dests = 6'd33;
    load_random(30, 33);
    send_group(30);
    collect("R9 30 by 33 random matrix R3", 30, 33, -1);
  endtask

  task automatic t_back_to_back;
    cfg_srcs = 6'd5; cfg_dests = 6'd8;
    load_random(5, 8);
    send_group(5);
    collect("R3 first group", 5, 8, -1);
    send_group(5);
    collect("R8 second group no carryover", 5, 8, -1);
  endtask

  task automatic t_stall;
    cfg_srcs = 6'd3; cfg_dests = 6'd6;
    load_random(3, 6);
    send_group(3);
    collect("R6 rows around stall", 3, 6, 2);
    send_group(3);
    collect("R10 group after blocked beats", 3, 6, -1);
  endtask

  task automatic t_rewrite;
    cfg_srcs = 6'd3; cfg_dests = 6'd6;
    write_coef(1, 0, vm[1][0] ^ 8'h5B);
    write_coef(4, 2, 8'h8E);
    send_group(3);
    collect("R2 rewritten coefficients", 3, 6, -1);
  endtask

  initial begin
    cfg_srcs = 6'd4; cfg_dests = 6'd7; cfg_we = 1'b0; cfg_row = '0; cfg_col = '0;
    cfg_coef = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    t_reset();
    t_unit_coefs();
    t_wide_config();
    t_back_to_back();
    t_stall();
    t_rewrite();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule